// File: doc/BRIEF.md
# Dual-Window Endianness Bridge

This block connects a big-endian processor-side memory bus to a little-endian device bus with a 32-bit data path. The downstream space can be reached through two address windows that alias the same device addresses at a fixed distance apart. Each window has its own way of crossing the endianness boundary. The first window keeps every byte address as it is and passes data lanes untouched, so multi-byte values read by software come out byte-swapped. The second window inverts the low address bits of sub-word accesses and mirrors the data lanes, so numeric values arrive intact at every access width. Software picks the policy for each access by choosing which window it uses.

Addresses outside both windows belong to local on-chip devices. Those accesses pass through with their address and data unchanged. The processor-side byte order is taken from a strap input that is sampled while reset is held. With the strap low, neither window translates anything. Every request is registered once. Its downstream strobe and its response appear in the next cycle. The response carries the device's read data, mapped back through the same lane rule.

Top module: `endian_window_bridge`

## Requirements
- R1: Size encoding is 00 byte, 01 halfword, 10 word, 11 invalid. An access inside either window (default bases 0x1000_0000 and 0x1010_0000, each 1 MiB) drives `dn_addr` with the offset within its window, with the upper bits zero.
- R2: In the lower (address-keeping) window the low two offset bits are kept. `dn_be` is 0001 shifted by the low bits for bytes, 0011 shifted by them for halfwords, and 1111 for words. Write and read data lanes pass unchanged (lane k is bits 8k+7:8k and carries byte address k).
- R3: In the upper (value-keeping) window, with the big-endian strap, the low offset bits are XORed with 3 for bytes and with 2 for halfwords. `dn_be` is formed from these mangled bits.
- R4: In the upper window an aligned word access keeps its address and drives `dn_be` = 1111.
- R5: In the upper window, with the big-endian strap, write data and returned read data are byte-mirrored (lane k swaps with lane 3-k) at every width.
- R6: An access outside both windows drives `dn_addr` equal to the request address and `dn_wdata` equal to the request data. Read data is returned unchanged, and `dn_be` comes straight from the address bits.
- R7: A halfword at an odd address, a word whose low two bits are not zero, or size code 11 gives `rsp_err` = 1 with `dn_valid` = 0 and `rsp_rdata` = 0.
- R8: A request accepted at a clock edge shows `dn_valid` (unless in error) and `rsp_valid` during the following cycle only. Back-to-back requests are answered in order, one per cycle.
- R9: `strap_be` is sampled only while reset is low. With it sampled low, the upper window behaves as the lower one. Changing the strap after reset has no effect.
- R10: While reset is held, `rsp_valid`, `dn_valid` and `rsp_err` are 0.
- R11: `dn_write` follows the request's write flag. A write response returns `rsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_be | input | 1 | Processor byte-order strap (1 = big-endian), sampled during reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 invalid |
| req_addr | input | ADDR_W | Processor byte address |
| req_wdata | input | 32 | Write data, lane k for byte address k |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Misaligned or invalid access |
| rsp_rdata | output | 32 | Read data mapped back to processor lanes |
| dn_valid | output | 1 | Downstream access strobe |
| dn_write | output | 1 | Downstream write flag |
| dn_addr | output | ADDR_W | Downstream byte address |
| dn_be | output | 4 | Downstream byte enables |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, valid while dn_valid is high |

## Verification
The assertions assume that no request is presented while reset is held. They also assume that the device answers reads in the same cycle as `dn_valid`, so `dn_rdata` depends only on the current downstream address. The stimulus drives requests only after reset is released, and at the falling edge. It models the device as a pure function of `dn_addr`, so each read's expected data follows from the address the bench predicts for that access. The strap is moved only around a fresh reset and once afterwards, which exercises the sampling rule without breaking the one-cycle timing the properties rely on.

// File: rtl/endian_window_bridge.sv
module endian_window_bridge #(
  parameter int ADDR_W = 32,
  parameter int WIN_LG = 20,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'h1000_0000,
  parameter logic [ADDR_W-1:0] WIN_GAP  = 'h0010_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_be,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              dn_valid,
  output logic              dn_write,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [3:0]        dn_be,
  output logic [31:0]       dn_wdata,
  input  logic [31:0]       dn_rdata
);
  localparam logic [ADDR_W-1:0] BASE_HI = WIN_BASE + WIN_GAP;
  localparam int TAG_W = ADDR_W - WIN_LG;

  function automatic logic [31:0] mirror(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  logic        be_mode, q_valid, q_err, q_mirror;
  logic        hit_lo, hit_hi, swap_now, misal;
  logic [1:0]  lo_bits, mlo;
  logic [3:0]  be_n;
  logic [ADDR_W-1:0] addr_n;

  assign hit_lo   = req_addr[ADDR_W-1:WIN_LG] == WIN_BASE[ADDR_W-1:WIN_LG];
  assign hit_hi   = req_addr[ADDR_W-1:WIN_LG] == BASE_HI[ADDR_W-1:WIN_LG];
  assign swap_now = hit_hi & be_mode;
  assign lo_bits  = req_addr[1:0];
  assign misal    = (req_size == 2'b11) | (req_size == 2'b01 & lo_bits[0])
                  | (req_size == 2'b10 & lo_bits != 2'b00);

  always_comb begin
    mlo = lo_bits;
    if (swap_now)
      mlo = lo_bits ^ ((req_size == 2'b00) ? 2'b11 :
                       (req_size == 2'b01) ? 2'b10 : 2'b00);
    case (req_size)
      2'b00:   be_n = 4'b0001 << mlo;
      2'b01:   be_n = 4'b0011 << mlo;
      default: be_n = 4'b1111;
    endcase
    if (hit_lo | hit_hi)
      addr_n = {{TAG_W{1'b0}}, req_addr[WIN_LG-1:2], mlo};
    else
      addr_n = req_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      be_mode  <= strap_be;
      q_valid  <= 1'b0;
      q_err    <= 1'b0;
      q_mirror <= 1'b0;
      dn_write <= 1'b0;
      dn_addr  <= '0;
      dn_be    <= '0;
      dn_wdata <= '0;
    end else begin
      q_valid <= req_valid;
      q_err   <= req_valid & misal;
      if (req_valid) begin
        q_mirror <= swap_now;
        dn_write <= req_write;
        dn_addr  <= addr_n;
        dn_be    <= be_n;
        dn_wdata <= swap_now ? mirror(req_wdata) : req_wdata;
      end
    end
  end

  assign rsp_valid = q_valid;
  assign rsp_err   = q_valid & q_err;
  assign dn_valid  = q_valid & ~q_err;
  assign rsp_rdata = (dn_valid & ~dn_write) ?
                     (q_mirror ? mirror(dn_rdata) : dn_rdata) : 32'h0;

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> rsp_valid == $past(req_valid));

  // R7
  misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_valid && misal)) |-> (rsp_err && !dn_valid && rsp_rdata == 32'h0));

  // R4
  full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_valid && req_size == 2'b10 && !misal))
      |-> (dn_be == 4'hF && dn_addr[1:0] == 2'b00));

  // R3
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_valid && req_size == 2'b00)) |-> $countones(dn_be) == 1);

  // R6
  local_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_valid && !hit_lo && !hit_hi && !misal))
      |-> (dn_addr == $past(req_addr) && dn_wdata == $past(req_wdata)));

  // R11
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && dn_write) |-> rsp_rdata == 32'h0);
endmodule

// File: tb/test_endian_window_bridge.sv
module test_endian_window_bridge;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, strap_be = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        rsp_valid, rsp_err, dn_valid, dn_write;
  logic [31:0] rsp_rdata, dn_addr, dn_wdata, dn_rdata;
  logic [3:0]  dn_be;

  int checks = 0, errors = 0;

  typedef struct {
    logic        wr;
    logic        err;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] rd;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] dev(input logic [31:0] a);
    return 32'hD3C2B1A0 ^ {4{a[7:0]}};
  endfunction

  function automatic logic [31:0] swp(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  assign dn_rdata = dev(dn_addr);

  endian_window_bridge i_endian_window_bridge (
    .clk(clk), .rst_n(rst_n), .strap_be(strap_be),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .dn_valid(dn_valid), .dn_write(dn_write), .dn_addr(dn_addr),
    .dn_be(dn_be), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata));

  task automatic issue(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] wd, input logic xe, input logic [31:0] xa,
                       input logic [3:0] xb, input logic [31:0] xw,
                       input logic [31:0] xr, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    e.wr = wr; e.err = xe; e.addr = xa; e.be = xb; e.wd = xw;
    e.rd = (wr || xe) ? 32'h0 : xr; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  initial begin : monitor
    exp_t e;
    logic ok;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (rsp_valid) begin
          checks++;
          if (sb.size() == 0) begin
            errors++;
            $display("FAIL R8 unexpected response: rsp_valid=%b expected 0", rsp_valid);
          end else begin
            e = sb.pop_front();
            ok = (rsp_err == e.err) && (dn_valid == !e.err) && (rsp_rdata == e.rd);
            if (!e.err)
              ok = ok && dn_write == e.wr && dn_addr == e.addr && dn_be == e.be
                      && (!e.wr || dn_wdata == e.wd);
            if (!ok) begin
              errors++;
              $display("FAIL %s: err=%b dv=%b addr=%h be=%b wd=%h rd=%h | expected err=%b addr=%h be=%b wd=%h rd=%h",
                       e.tag, rsp_err, dn_valid, dn_addr, dn_be, dn_wdata, rsp_rdata,
                       e.err, e.addr, e.be, e.wd, e.rd);
            end
          end
        end else if (dn_valid || sb.size() > 1) begin
          checks++; errors++;
          $display("FAIL R8 strobe/response mismatch: dn_valid=%b pending=%0d expected 0 and <=1",
                   dn_valid, sb.size());
        end
      end
    end
  end

  initial begin : watchdog
    #(PERIOD*100000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    checks++; // R10 quiet outputs during reset
    if (rsp_valid || dn_valid || rsp_err) begin
      errors++;
      $display("FAIL R10 reset: rv=%b dv=%b err=%b expected 0 0 0", rsp_valid, dn_valid, rsp_err);
    end
    rst_n = 1'b1;
    // R2 lower window keeps addresses and lanes
    issue(1, 2'b00, 32'h1000_0011, 32'h0000_CD00, 0, 32'h11, 4'b0010, 32'h0000_CD00, 0, "R2 byte write low window");
    issue(0, 2'b01, 32'h1000_0022, 0, 0, 32'h22, 4'b1100, 0, dev(32'h22), "R2 R1 half read low window");
    // R3 R5 upper window mangles sub-word addresses
    issue(1, 2'b00, 32'h1010_0011, 32'h0000_CD00, 0, 32'h12, 4'b0100, 32'h00CD_0000, 0, "R3 R5 byte write high window");
    issue(1, 2'b01, 32'h1010_0022, 32'hBEEF_0000, 0, 32'h20, 4'b0011, 32'h0000_EFBE, 0, "R3 R5 half write high window");
    issue(0, 2'b00, 32'h1010_0043, 0, 0, 32'h40, 4'b0001, 0, swp(dev(32'h40)), "R3 R5 byte read high window");
    // R4 aligned words keep their address
    issue(1, 2'b10, 32'h1010_0080, 32'h1122_3344, 0, 32'h80, 4'b1111, 32'h4433_2211, 0, "R4 R11 word write high window");
    issue(0, 2'b10, 32'h1010_0084, 0, 0, 32'h84, 4'b1111, 0, swp(dev(32'h84)), "R4 R5 word read high window");
    issue(0, 2'b10, 32'h1000_0084, 0, 0, 32'h84, 4'b1111, 0, dev(32'h84), "R2 word read low window");
    // R6 local pass-through
    issue(1, 2'b01, 32'h2000_0106, 32'h5566_0000, 0, 32'h2000_0106, 4'b1100, 32'h5566_0000, 0, "R6 local half write");
    issue(0, 2'b10, 32'h2000_0200, 0, 0, 32'h2000_0200, 4'b1111, 0, dev(32'h2000_0200), "R6 local word read");
    // R7 misaligned and invalid
    issue(0, 2'b01, 32'h1010_0001, 0, 1, 0, 0, 0, 0, "R7 odd half");
    issue(1, 2'b10, 32'h1000_0002, 32'hFFFF_FFFF, 1, 0, 0, 0, 0, "R7 misaligned word");
    issue(0, 2'b11, 32'h1000_0000, 0, 1, 0, 0, 0, 0, "R7 invalid size");
    idle(1);
    // R8 isolated request after a gap
    issue(0, 2'b00, 32'h1000_0005, 0, 0, 32'h05, 4'b0010, 0, dev(32'h05), "R8 isolated byte read");
    idle(3);
    // R9 re-strap little-endian
    rst_n = 1'b0; strap_be = 1'b0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    strap_be = 1'b1;
    issue(1, 2'b00, 32'h1010_0011, 32'h0000_CD00, 0, 32'h11, 4'b0010, 32'h0000_CD00, 0, "R9 byte write high window LE strap");
    issue(0, 2'b10, 32'h1010_0084, 0, 0, 32'h84, 4'b1111, 0, dev(32'h84), "R9 word read high window LE strap");
    idle(3);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R8 responses missing: pending=%0d expected 0", sb.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule